// File: doc/BRIEF.md
# Reverse-Subtract Add/Compare Unit

This unit is the integer add/subtract slice of a 32-bit RISC execute stage. Each valid cycle it takes two operands, a 6-bit major opcode, an 11-bit function field, the current carry flag and an immediate-select bit. One clock later it returns a registered result, the carry produced by the addition, and a strobe that says whether the carry flag in the status register is to be overwritten. The carry flag itself lives outside the unit; the unit only reads it through `carry_in` and proposes a new value through `carry_out`/`carry_we`.

Subtraction is reversed: the second operand minus the first. Three low opcode bits independently pick subtraction, use of the incoming carry in place of the constant, and keep-carry. With the register form of the keep-carry reverse subtract, two function codes turn the operation into a signed or unsigned compare. A compare replaces the result's most significant bit with an ordering flag. Vectors are declared `[31:0]`; bit 31 is the most significant bit, which is bit 0 in big-endian numbering.

Top module: `rsc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_vld`, `carry_we`, `result` and `carry_out` are all 0 after that edge, whatever the other inputs are.
- R2: An operation presented with `in_vld`=1 at an edge shows `res_vld`=1 right after that edge. The legal opcodes are 0x00 to 0x0D. Any other opcode (0x0E, 0x0F, or bits [5:4] nonzero) gives `res_vld`=0 and `carry_we`=0.
- R3: With `opcode[0]`=0 the result is A + B + c. Here c is `carry_in` when `opcode[1]`=1 and 0 otherwise.
- R4: With `opcode[0]`=1 the result is B + ~A + c. Here c is `carry_in` when `opcode[1]`=1 and 1 otherwise.
- R5: `carry_out` is bit 32 of the 33-bit sum. With `opcode[2]`=0 on a legal opcode, `carry_we` is 1.
- R6: With `opcode[2]`=1 (keep-carry, which includes both compares), `carry_we` is 0.
- R7: With `imm_sel`=1, operand B is `imm` sign-extended from bit 15 and `opnd_b` is ignored. Otherwise B is `opnd_b`.
- R8: Opcode 0x05 with `imm_sel`=0 and `func`=0x001 is a signed compare. The result is B + ~A + 1 with bit 31 replaced by 1 when B < A (signed) and by 0 otherwise.
- R9: Opcode 0x05 with `imm_sel`=0 and `func`=0x003 behaves as R8 but orders the operands as unsigned.
- R10: Opcode 0x05 with any other `func` value, or with `imm_sel`=1, is a plain keep-carry reverse subtract with bit 31 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation present this cycle |
| opcode | input | 6 | Major opcode |
| func | input | 11 | Function field (compare select) |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B (register form) |
| imm | input | 16 | Immediate, sign-extended when selected |
| imm_sel | input | 1 | Use immediate as operand B |
| carry_in | input | 1 | Current carry flag |
| res_vld | output | 1 | Registered result valid |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Carry of the addition |
| carry_we | output | 1 | Carry flag is to be written |

## Verification
The bench works on the operands where carry and sign meet: 0, all ones, 0x80000000 and 0x7FFFFFFF in every pairing, with both carry-in values, on every opcode including the two illegal codes at the top of the group. A design that computed A minus B would give the negated result on every reverse subtract. One that ignored the incoming carry would be off by one on the carry-in variants. One that took the signed ordering from the difference's sign alone would misorder 0x80000000 against 0x7FFFFFFF. Compares are also issued with neighbouring function codes and in immediate form, where a decoder that is too loose would wrongly overwrite bit 31. A design that left `carry_we` on for keep-carry opcodes would corrupt the flag after every compare.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int OPC_W  = 6;
  localparam int FUNC_W = 11;

  localparam logic [OPC_W-1:0]  OPC_CMP_HOST = 6'b000101;
  localparam logic [FUNC_W-1:0] FUNC_CMP_S   = 11'h001;
  localparam logic [FUNC_W-1:0] FUNC_CMP_U   = 11'h003;

  typedef struct packed {
    logic legal;    // opcode belongs to this arithmetic group
    logic inv_a;    // reverse subtract: invert operand A
    logic use_cin;  // take carry flag instead of the constant
    logic keep;     // leave carry flag untouched
  } op_ctl_t;

  typedef enum logic [1:0] {
    CMP_OFF      = 2'd0,
    CMP_SIGNED   = 2'd1,
    CMP_UNSIGNED = 2'd2
  } cmp_mode_t;

  function automatic op_ctl_t decode_op(input logic [OPC_W-1:0] op);
    op_ctl_t c;
    c.legal   = (op[5:4] == 2'b00) && !(op[3:1] == 3'b111);
    c.inv_a   = op[0];
    c.use_cin = op[1];
    c.keep    = op[2];
    return c;
  endfunction

  function automatic cmp_mode_t decode_cmp(input logic [OPC_W-1:0] op,
                                           input logic [FUNC_W-1:0] fn,
                                           input logic imm_form);
    cmp_mode_t m;
    m = CMP_OFF;
    if (op == OPC_CMP_HOST && !imm_form) begin
      if (fn == FUNC_CMP_S)      m = CMP_SIGNED;
      else if (fn == FUNC_CMP_U) m = CMP_UNSIGNED;
    end
    return m;
  endfunction

endpackage

// File: rtl/rsc_opnd.sv
module rsc_opnd
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  input  op_ctl_t           ctl_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic              cin_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    y_o   = imm_sel_i ? imm_ext : b_i;
    x_o   = ctl_i.inv_a ? ~a_i : a_i;
    cin_o = ctl_i.use_cin ? flag_i : ctl_i.inv_a;
  end

endmodule

// File: rtl/rsc_adder.sv
module rsc_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);

  logic [DATA_W:0] wide;

  always_comb begin
    wide   = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
    sum_o  = wide[DATA_W-1:0];
    cout_o = wide[DATA_W];
  end

endmodule

// File: rtl/rsc_cmp.sv
module rsc_cmp
  import rsc_pkg::*;
(
  input  cmp_mode_t mode_i,
  input  logic      a_msb_i,
  input  logic      b_msb_i,
  input  logic      diff_msb_i,
  input  logic      cout_i,
  output logic      active_o,
  output logic      b_lt_a_o
);

  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    // Signs differ: B is below A exactly when B is negative.
    lt_signed   = (a_msb_i ^ b_msb_i) ? b_msb_i : diff_msb_i;
    // B + ~A + 1 carries out when no borrow, i.e. B >= A.
    lt_unsigned = !cout_i;
    active_o    = (mode_i != CMP_OFF);
    unique case (mode_i)
      CMP_SIGNED:   b_lt_a_o = lt_signed;
      CMP_UNSIGNED: b_lt_a_o = lt_unsigned;
      default:      b_lt_a_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rsc_unit.sv
module rsc_unit
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [5:0]        opcode,
  input  logic [10:0]       func,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              imm_sel,
  input  logic              carry_in,
  output logic              res_vld,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_we
);

  localparam int MSB = DATA_W - 1;

  op_ctl_t           ctl;
  cmp_mode_t         cmode;
  logic [DATA_W-1:0] x_val, y_val, sum_val, res_next;
  logic              cin_val, cout_val, cmp_on, cmp_lt;
  logic              accept;

  always_comb begin
    ctl    = decode_op(opcode);
    cmode  = decode_cmp(opcode, func, imm_sel);
    accept = in_vld && ctl.legal;
  end

  rsc_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .a_i       (opnd_a),
    .b_i       (opnd_b),
    .imm_i     (imm),
    .imm_sel_i (imm_sel),
    .ctl_i     (ctl),
    .flag_i    (carry_in),
    .x_o       (x_val),
    .y_o       (y_val),
    .cin_o     (cin_val)
  );

  rsc_adder #(.DATA_W(DATA_W)) u_add (
    .x_i    (x_val),
    .y_i    (y_val),
    .cin_i  (cin_val),
    .sum_o  (sum_val),
    .cout_o (cout_val)
  );

  rsc_cmp u_cmp (
    .mode_i     (cmode),
    .a_msb_i    (opnd_a[MSB]),
    .b_msb_i    (y_val[MSB]),
    .diff_msb_i (sum_val[MSB]),
    .cout_i     (cout_val),
    .active_o   (cmp_on),
    .b_lt_a_o   (cmp_lt)
  );

  always_comb begin
    res_next = sum_val;
    if (cmp_on) res_next[MSB] = cmp_lt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      carry_we  <= 1'b0;
      carry_out <= 1'b0;
      result    <= '0;
    end else begin
      res_vld  <= accept;
      carry_we <= accept && !ctl.keep;
      if (accept) begin
        result    <= res_next;
        carry_out <= cout_val;
      end
    end
  end

endmodule

// File: rtl/rsc_unit_chk.sv
module rsc_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [5:0]        opcode,
  input logic [10:0]       func,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [IMM_W-1:0]  imm,
  input logic              imm_sel,
  input logic              carry_in,
  input logic              res_vld,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              carry_we
);

  logic grp_ok;
  assign grp_ok = (opcode[5:4] == 2'b00) && (opcode[3:1] != 3'b111);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!res_vld && !carry_we && !carry_out && result == '0));

  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && !grp_ok)) |-> (!res_vld && !carry_we));

  // R2
  legal_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && grp_ok)) |-> res_vld);

  // R3
  plain_add_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && opcode == 6'd0 && !imm_sel))
      |-> (result == $past(opnd_a) + $past(opnd_b)));

  // R5
  carry_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && grp_ok && !opcode[2])) |-> carry_we);

  // R6
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && opcode[2])) |-> !carry_we);

  // R8
  cmp_signed_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && opcode == 6'd5 && !imm_sel && func == 11'h001))
      |-> (result[DATA_W-1] == ($signed($past(opnd_b)) < $signed($past(opnd_a)))));

  // R9
  cmp_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld && opcode == 6'd5 && !imm_sel && func == 11'h003))
      |-> (result[DATA_W-1] == ($past(opnd_b) < $past(opnd_a))));

endmodule

bind rsc_unit rsc_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_vld    (in_vld),
  .opcode    (opcode),
  .func      (func),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .imm       (imm),
  .imm_sel   (imm_sel),
  .carry_in  (carry_in),
  .res_vld   (res_vld),
  .result    (result),
  .carry_out (carry_out),
  .carry_we  (carry_we)
);

// File: tb/rsc_unit_tb.sv
module rsc_unit_tb;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [5:0]    opcode = '0;
  logic [10:0]   func = '0;
  logic [W-1:0]  opnd_a = '0;
  logic [W-1:0]  opnd_b = '0;
  logic [15:0]   imm = '0;
  logic          imm_sel = 1'b0;
  logic          carry_in = 1'b0;
  logic          res_vld;
  logic [W-1:0]  result;
  logic          carry_out;
  logic          carry_we;

  always #10 clk = ~clk;  // 50 MHz

  rsc_unit #(.DATA_W(W), .IMM_W(16)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opcode(opcode), .func(func),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .imm_sel(imm_sel),
    .carry_in(carry_in), .res_vld(res_vld), .result(result),
    .carry_out(carry_out), .carry_we(carry_we)
  );

  typedef struct {
    logic         vld;
    logic [W-1:0] res;
    logic         we;
    logic         cout;
    string        tag;
    string        ctag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  logic [W-1:0] corners [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000,
                                32'h7FFF_FFFF, 32'h1};

  function automatic exp_t model(logic [5:0] op, logic [10:0] fn,
                                 logic [W-1:0] a, logic [W-1:0] b,
                                 logic [15:0] im, logic isel, logic cin);
    exp_t e;
    logic [W-1:0] bb, aa;
    logic [W:0]   s;
    logic         c, legal, cmp;
    bb    = isel ? {{16{im[15]}}, im} : b;                 // R7
    legal = (op < 6'd14);                                  // R2
    aa    = op[0] ? ~a : a;                                // R3 / R4
    c     = op[1] ? cin : op[0];
    s     = {1'b0, aa} + {1'b0, bb} + {{W{1'b0}}, c};
    cmp   = (op == 6'd5) && !isel && (fn == 11'h001 || fn == 11'h003);
    e.vld = legal;
    e.res = s[W-1:0];
    if (cmp) e.res[W-1] = (fn == 11'h001) ? ($signed(bb) < $signed(a)) : (bb < a);
    e.we   = legal && !op[2];
    e.cout = s[W];
    if (!legal)                                 e.tag = "R2";
    else if (cmp && fn == 11'h001)              e.tag = "R8";
    else if (cmp)                               e.tag = "R9";
    else if (op == 6'd5 && (isel || fn != 0))   e.tag = "R10";
    else if (isel)                              e.tag = "R7";
    else if (op[0])                             e.tag = "R4";
    else                                        e.tag = "R3";
    e.ctag = (legal && !op[2]) ? "R5" : "R6";
    return e;
  endfunction

  task automatic issue(logic [5:0] op, logic [10:0] fn, logic [W-1:0] a,
                       logic [W-1:0] b, logic [15:0] im, logic isel, logic cin);
    @(negedge clk);
    in_vld = 1'b1; opcode = op; func = fn; opnd_a = a; opnd_b = b;
    imm = im; imm_sel = isel; carry_in = cin;
    q.push_back(model(op, fn, a, b, im, isel, cin));
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // Monitor: pops one expected item per issued cycle, 5 ns after the edge.
  always @(posedge clk) begin
    #5;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res_vld !== e.vld || (e.vld && result !== e.res)) begin
        fails++;
        $display("FAIL %s vld/result actual=%0b/%h expected=%0b/%h",
                 e.tag, res_vld, result, e.vld, e.res);
      end
      checks++;
      if (carry_we !== e.we || (e.we && carry_out !== e.cout)) begin
        fails++;
        $display("FAIL %s carry_we/carry_out actual=%0b/%0b expected=%0b/%0b",
                 e.ctag, carry_we, carry_out, e.we, e.cout);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a valid operation presented during reset.
    @(negedge clk);
    in_vld = 1'b1; opcode = 6'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || carry_we !== 1'b0 || carry_out !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 actual=%0b/%0b/%0b/%h expected=0/0/0/00000000",
               res_vld, carry_we, carry_out, result);
    end
    in_vld = 1'b0;
    rst = 1'b0;

    // R3 R4 R5 R6 R2: every opcode of the group plus two illegal ones, corners.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int c = 0; c < 2; c++)
            issue(6'(op), 11'h0, corners[i], corners[j], 16'h0, 1'b0, c[0]);
    idle();

    // R2: out-of-group opcodes.
    issue(6'h10, 11'h0, 32'h5, 32'h3, 16'h0, 1'b0, 1'b1);
    issue(6'h3F, 11'h0, 32'h5, 32'h3, 16'h0, 1'b0, 1'b1);
    issue(6'h20, 11'h1, 32'h5, 32'h3, 16'h0, 1'b0, 1'b0);
    idle();

    // R8 R9 R10: compare codes and near misses over the corners.
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        issue(6'd5, 11'h001, corners[i], corners[j], 16'h0, 1'b0, 1'b0);
        issue(6'd5, 11'h003, corners[i], corners[j], 16'h0, 1'b0, 1'b1);
        issue(6'd5, 11'h002, corners[i], corners[j], 16'h0, 1'b0, 1'b0);
        issue(6'd5, 11'h001, corners[i], corners[j], 16'h8000, 1'b1, 1'b0);
      end
    idle();

    // R7: immediate forms with sign-extension edges.
    for (int op = 8; op < 14; op++) begin
      issue(6'(op), 11'h0, 32'h1, 32'hDEAD_BEEF, 16'h8000, 1'b1, 1'b1);
      issue(6'(op), 11'h0, 32'h8000_0000, 32'h0, 16'h7FFF, 1'b1, 1'b0);
      issue(6'(op), 11'h0, 32'hFFFF_FFFF, 32'h1234_5678, 16'hFFFF, 1'b1, 1'b1);
    end
    idle();

    // Random mix, back to back, with occasional bubbles.
    for (int k = 0; k < 400; k++) begin
      logic [5:0] rop;
      logic [10:0] rfn;
      rop = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 16);
      rfn = ($urandom % 2 == 0) ? 11'($urandom % 4) : 11'($urandom);
      issue(rop, rfn, $urandom, $urandom, 16'($urandom), 1'($urandom),
            1'($urandom));
      if (k % 37 == 0) idle();
    end
    idle();

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule